// File: doc/BRIEF.md
# Memory Decoder Register File

This block holds the software-visible control and status words for a small, parameterised set of host-managed memory address decoders. Software reaches it through a plain 32-bit register port: a read strobe, a write strobe, a byte address, four byte enables and write data. One cycle after any strobe the block returns read data and an error flag. It keeps a read-only capability word, a global control word, a global status word, and for each decoder a group of five registers: two halves of a base address, two halves of a size, and a control word.

Writes pass through a per-register mask so that reserved bits always read back as zero. Each decoder control word carries a commit request bit whose value is copied into a committed flag by the same write, so no polling loop is needed. A lock bit freezes the decoder's whole group until reset. Writes to read-only words are dropped quietly, while accesses that are not whole aligned dwords, or that fall past the last decoder group, get an error response and change nothing. The committed flags and the global enable are also brought out as ports for the address-decoding logic that uses them.

Top module: `mdec_regfile`

## Requirements
- R1: After reset every writable field is zero (all decoder words, global control, committed flags, lock bits), and the capability word reads the decoder count in bits [3:0] with all other bits zero.
- R2: A strobe whose address has bits [1:0] not zero, or whose byte enables are not 4'b1111, gets rsp_err=1 in the next cycle and changes no register.
- R3: A strobe at an address at or above 0x10 + NUM_DEC*0x20, or a cycle with both acc_rd and acc_wr high, gets rsp_err=1 in the next cycle and changes no register.
- R4: In the cycle after a strobe, rsp_rdata holds the addressed word for a good read and zero for a write or an error; in a cycle after no strobe, rsp_err and rsp_rdata are both zero.
- R5: The capability word at 0x00 is read-only; a write to it is dropped with rsp_err=0.
- R6: Global control at 0x04 stores bits [1:0], bits [31:2] read 0, and bit 1 drives dec_global_en. Global status at 0x08 is read-only and bit n reads the committed flag of decoder n.
- R7: Decoder n's group starts at 0x10 + n*0x20 with base-low at +0x00, base-high +0x04, size-low +0x08, size-high +0x0C, control +0x10. The low words keep only bits [31:28] (writing 0xFFFFFFFF reads 0xF0000000); the high words keep all 32 bits.
- R8: In decoder control, bit 15 and bits [31:28] read 0 and bit 10 (committed) cannot be written directly; other bits are stored.
- R9: A control write with bit 9 (commit) set makes bit 10 read 1 on the very next read and raises dec_committed[n]; a control write with bit 9 clear clears both.
- R10: While bit 8 (lock) of a decoder's control is set, writes to that decoder's base, size and control words are dropped without error; other decoders are unaffected.
- R11: The unused word at 0x0C and group offsets +0x14, +0x18, +0x1C read zero, drop writes and give no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| acc_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| rsp_err | output | 1 | Error response, the cycle after a strobe |
| dec_global_en | output | 1 | Global decoder enable from global control bit 1 |
| dec_committed | output | NUM_DEC | Committed flag of each decoder |

## Verification
The register masks are driven with all-ones patterns, which separate stored bits from reserved bits in each word type, and with sparse patterns such as a lone commit bit or a lone committed bit, which tell a correct commit copy apart from a plain stored bit. Lock is set on the second decoder only, so that a dropped write there can be told apart from a write that leaks into the first decoder's group. Misaligned addresses, partial byte enables, out-of-range addresses and double strobes are each followed by a read of the word they would have hit, showing that an error leaves state untouched, and a mid-run reset shows that lock and commit state return to zero.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Register target selected by the address decoder
  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_CAP,
    TGT_GCTRL,
    TGT_GSTAT,
    TGT_BLO,
    TGT_BHI,
    TGT_SLO,
    TGT_SHI,
    TGT_CTRL
  } tgt_e;

  // Per-decoder register group
  typedef struct packed {
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] size_lo;
    logic [31:0] size_hi;
    logic [31:0] ctrl;
  } dec_regs_t;

  // Write masks: ones mark stored bits
  localparam logic [31:0] GCTRL_WMASK = 32'h0000_0003;
  localparam logic [31:0] LOW_WMASK   = 32'hF000_0000;
  localparam logic [31:0] CTRL_WMASK  = 32'h0FFF_7BFF;

  // Control bit positions
  localparam int CTRL_LOCK   = 8;
  localparam int CTRL_COMMIT = 9;
  localparam int CTRL_DONE   = 10;

  // Global control enable bit
  localparam int GCTRL_EN = 1;

endpackage

// File: rtl/mdec_addr_decode.sv
module mdec_addr_decode
  import mdec_pkg::*;
#(
  parameter int NUM_DEC = 2,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              bad
);

  localparam int WA_W = ADDR_W - 2;
  localparam int GR_W = ADDR_W - 5;
  localparam logic [GR_W-1:0] GROUPS = GR_W'(NUM_DEC);

  logic [WA_W-1:0] woff;
  logic [GR_W-1:0] group;
  logic            low_page;
  logic            misaligned;

  // Word offset relative to the first decoder group (0x10 -> word 4)
  assign woff       = addr[ADDR_W-1:2] - WA_W'(4);
  assign group      = woff[WA_W-1:3];
  assign low_page   = (addr[ADDR_W-1:4] == '0);
  assign misaligned = (addr[1:0] != 2'b00) || (be != 4'hF);

  always_comb begin
    tgt = TGT_NONE;
    idx = '0;
    bad = 1'b0;
    if (misaligned) begin
      bad = 1'b1;
    end else if (low_page) begin
      case (addr[3:2])
        2'd0:    tgt = TGT_CAP;
        2'd1:    tgt = TGT_GCTRL;
        2'd2:    tgt = TGT_GSTAT;
        default: tgt = TGT_NONE;
      endcase
    end else if (group >= GROUPS) begin
      bad = 1'b1;
    end else begin
      idx = woff[3 +: IDX_W];
      case (woff[2:0])
        3'd0:    tgt = TGT_BLO;
        3'd1:    tgt = TGT_BHI;
        3'd2:    tgt = TGT_SLO;
        3'd3:    tgt = TGT_SHI;
        3'd4:    tgt = TGT_CTRL;
        default: tgt = TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mdec_glob_regs.sv
module mdec_glob_regs
  import mdec_pkg::*;
#(
  parameter int NUM_DEC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  tgt_e               tgt,
  input  logic [31:0]        wdata,
  input  logic [NUM_DEC-1:0] committed,
  output logic [31:0]        cap_word,
  output logic [31:0]        gctrl_word,
  output logic [31:0]        gstat_word
);

  logic [31:0] gctrl_q;
  logic [31:0] gctrl_d;
  logic        gctrl_en;

  // Capability: decoder count in [3:0], constant
  assign cap_word   = {28'd0, 4'(NUM_DEC)};
  assign gstat_word = 32'(committed);

  assign gctrl_en = wr_ok && (tgt == TGT_GCTRL);
  assign gctrl_d  = wdata & GCTRL_WMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctrl_q <= '0;
    end else if (gctrl_en) begin
      gctrl_q <= gctrl_d;
    end
  end

  assign gctrl_word = gctrl_q;

endmodule

// File: rtl/mdec_dec_slot.sv
module mdec_dec_slot
  import mdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  tgt_e        tgt,
  input  logic [31:0] wdata,
  output dec_regs_t   regs,
  output logic        committed
);

  dec_regs_t cur;
  dec_regs_t nxt;
  logic      upd;

  // Lock freezes the whole group until reset
  assign upd = wr_sel && !cur.ctrl[CTRL_LOCK];

  always_comb begin
    nxt = cur;
    case (tgt)
      TGT_BLO: nxt.base_lo = wdata & LOW_WMASK;
      TGT_BHI: nxt.base_hi = wdata;
      TGT_SLO: nxt.size_lo = wdata & LOW_WMASK;
      TGT_SHI: nxt.size_hi = wdata;
      TGT_CTRL: begin
        nxt.ctrl            = wdata & CTRL_WMASK;
        nxt.ctrl[CTRL_DONE] = wdata[CTRL_COMMIT];
      end
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (upd) begin
      cur <= nxt;
    end
  end

  assign regs      = cur;
  assign committed = cur.ctrl[CTRL_DONE];

endmodule

// File: rtl/mdec_regfile.sv
module mdec_regfile
  import mdec_pkg::*;
#(
  parameter int NUM_DEC = 2,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [3:0]         acc_be,
  input  logic [31:0]        acc_wdata,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               dec_global_en,
  output logic [NUM_DEC-1:0] dec_committed
);

  localparam int IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;

  tgt_e             tgt;
  logic [IDX_W-1:0] idx;
  logic             dec_bad;
  logic             any_acc;
  logic             acc_bad;
  logic             wr_ok;
  logic             rd_ok;
  logic [31:0]      cap_word;
  logic [31:0]      gctrl_word;
  logic [31:0]      gstat_word;
  logic [31:0]      rd_val;
  logic [31:0]      rdata_d;
  logic             err_d;
  dec_regs_t        dregs [NUM_DEC];

  mdec_addr_decode #(
    .NUM_DEC (NUM_DEC),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_dec (
    .addr (acc_addr),
    .be   (acc_be),
    .tgt  (tgt),
    .idx  (idx),
    .bad  (dec_bad)
  );

  assign any_acc = acc_rd || acc_wr;
  assign acc_bad = dec_bad || (acc_rd && acc_wr);
  assign wr_ok   = acc_wr && !acc_bad;
  assign rd_ok   = acc_rd && !acc_bad;

  mdec_glob_regs #(
    .NUM_DEC (NUM_DEC)
  ) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ok      (wr_ok),
    .tgt        (tgt),
    .wdata      (acc_wdata),
    .committed  (dec_committed),
    .cap_word   (cap_word),
    .gctrl_word (gctrl_word),
    .gstat_word (gstat_word)
  );

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    logic sel;
    assign sel = wr_ok && (idx == IDX_W'(g));
    mdec_dec_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (sel),
      .tgt       (tgt),
      .wdata     (acc_wdata),
      .regs      (dregs[g]),
      .committed (dec_committed[g])
    );
  end

  // Read mux
  always_comb begin
    case (tgt)
      TGT_CAP:   rd_val = cap_word;
      TGT_GCTRL: rd_val = gctrl_word;
      TGT_GSTAT: rd_val = gstat_word;
      TGT_BLO:   rd_val = dregs[idx].base_lo;
      TGT_BHI:   rd_val = dregs[idx].base_hi;
      TGT_SLO:   rd_val = dregs[idx].size_lo;
      TGT_SHI:   rd_val = dregs[idx].size_hi;
      TGT_CTRL:  rd_val = dregs[idx].ctrl;
      default:   rd_val = '0;
    endcase
  end

  // Response next state
  always_comb begin
    err_d   = any_acc && acc_bad;
    rdata_d = rd_ok ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end

  assign dec_global_en = gctrl_word[GCTRL_EN];

endmodule

// File: rtl/mdec_regfile_chk.sv
module mdec_regfile_chk #(
  parameter int NUM_DEC = 2,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_rd,
  input logic               acc_wr,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [3:0]         acc_be,
  input logic [31:0]        rsp_rdata,
  input logic               rsp_err,
  input logic [NUM_DEC-1:0] dec_committed
);

  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(16 + NUM_DEC * 32);

  // R2: partial or misaligned strobes draw an error
  p_misalign_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) && ((acc_addr[1:0] != 2'b00) || (acc_be != 4'hF)) |=> rsp_err);

  // R3: out-of-range single strobes draw an error
  p_beyond_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd ^ acc_wr) && (acc_addr >= END_ADDR) |=> rsp_err);

  // R3: double strobe draws an error
  p_double_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_wr) |=> rsp_err);

  // R4: idle cycle gives a quiet response
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd || acc_wr) |=> (!rsp_err && (rsp_rdata == 32'd0)));

  // R5: capability read returns the decoder count
  p_cap_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && !acc_wr && (acc_addr == '0) && (acc_be == 4'hF)
    |=> (rsp_rdata == 32'(NUM_DEC)) && !rsp_err);

  // R6: global control upper bits read zero
  p_gctrl_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && !acc_wr && (acc_addr == ADDR_W'(4)) && (acc_be == 4'hF)
    |=> (rsp_rdata[31:2] == 30'd0));

  // R7: first decoder base-low keeps only [31:28]
  p_lo_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && !acc_wr && (acc_addr == ADDR_W'(16)) && (acc_be == 4'hF)
    |=> (rsp_rdata[27:0] == 28'd0));

  // R9: committed flags move only on a write
  p_commit_only_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(dec_committed));

  // R2: rejected partial writes leave committed flags alone
  p_bad_write_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && (acc_be != 4'hF) |=> $stable(dec_committed));

endmodule

bind mdec_regfile mdec_regfile_chk #(
  .NUM_DEC (NUM_DEC),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_rd        (acc_rd),
  .acc_wr        (acc_wr),
  .acc_addr      (acc_addr),
  .acc_be        (acc_be),
  .rsp_rdata     (rsp_rdata),
  .rsp_err       (rsp_err),
  .dec_committed (dec_committed)
);

// File: tb/sim_mdec_regfile.sv
module sim_mdec_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEC    = 2;
  localparam int ADDR_W     = 12;

  typedef struct packed {
    logic [3:0]        req;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic [31:0]       exp;
    logic              err;
  } vec_t;

  localparam int NV = 39;
  // Decoder 0 group at 0x010, decoder 1 group at 0x030, first bad address 0x050
  localparam vec_t VT [NV] = '{
    '{4'd5,  1'b0, 12'h000, 32'h0,        32'h2,        1'b0}, // R5 capability
    '{4'd5,  1'b1, 12'h000, 32'hFFFFFFFF, 32'h0,        1'b0}, // R5 write dropped
    '{4'd5,  1'b0, 12'h000, 32'h0,        32'h2,        1'b0}, // R5 unchanged
    '{4'd6,  1'b1, 12'h004, 32'hFFFFFFFF, 32'h0,        1'b0}, // R6
    '{4'd6,  1'b0, 12'h004, 32'h0,        32'h3,        1'b0}, // R6 mask
    '{4'd7,  1'b1, 12'h010, 32'hFFFFFFFF, 32'h0,        1'b0}, // R7
    '{4'd7,  1'b0, 12'h010, 32'h0,        32'hF0000000, 1'b0}, // R7 base low
    '{4'd7,  1'b1, 12'h014, 32'h12345678, 32'h0,        1'b0}, // R7
    '{4'd7,  1'b0, 12'h014, 32'h0,        32'h12345678, 1'b0}, // R7 base high
    '{4'd7,  1'b1, 12'h018, 32'hABCDEF01, 32'h0,        1'b0}, // R7
    '{4'd7,  1'b0, 12'h018, 32'h0,        32'hA0000000, 1'b0}, // R7 size low
    '{4'd7,  1'b1, 12'h01C, 32'h000000FF, 32'h0,        1'b0}, // R7
    '{4'd7,  1'b0, 12'h01C, 32'h0,        32'h000000FF, 1'b0}, // R7 size high
    '{4'd8,  1'b1, 12'h020, 32'hFFFFFEFF, 32'h0,        1'b0}, // R8
    '{4'd8,  1'b0, 12'h020, 32'h0,        32'h0FFF7EFF, 1'b0}, // R8 ctrl mask
    '{4'd6,  1'b0, 12'h008, 32'h0,        32'h1,        1'b0}, // R6 status
    '{4'd9,  1'b1, 12'h020, 32'h0,        32'h0,        1'b0}, // R9 uncommit
    '{4'd9,  1'b0, 12'h020, 32'h0,        32'h0,        1'b0}, // R9
    '{4'd9,  1'b0, 12'h008, 32'h0,        32'h0,        1'b0}, // R9 status clear
    '{4'd8,  1'b1, 12'h020, 32'h00000400, 32'h0,        1'b0}, // R8 direct committed
    '{4'd8,  1'b0, 12'h020, 32'h0,        32'h0,        1'b0}, // R8 not writable
    '{4'd9,  1'b1, 12'h020, 32'h00000200, 32'h0,        1'b0}, // R9 commit
    '{4'd9,  1'b0, 12'h020, 32'h0,        32'h00000600, 1'b0}, // R9 next read
    '{4'd11, 1'b1, 12'h00C, 32'hFFFFFFFF, 32'h0,        1'b0}, // R11
    '{4'd11, 1'b0, 12'h00C, 32'h0,        32'h0,        1'b0}, // R11
    '{4'd11, 1'b1, 12'h024, 32'h00000005, 32'h0,        1'b0}, // R11 group gap
    '{4'd11, 1'b0, 12'h024, 32'h0,        32'h0,        1'b0}, // R11
    '{4'd3,  1'b0, 12'h050, 32'h0,        32'h0,        1'b1}, // R3 beyond
    '{4'd3,  1'b1, 12'h050, 32'h1,        32'h0,        1'b1}, // R3 beyond
    '{4'd10, 1'b0, 12'h030, 32'h0,        32'h0,        1'b0}, // R10
    '{4'd10, 1'b1, 12'h040, 32'h00000100, 32'h0,        1'b0}, // R10 lock dec 1
    '{4'd10, 1'b0, 12'h040, 32'h0,        32'h00000100, 1'b0}, // R10
    '{4'd10, 1'b1, 12'h030, 32'hFFFFFFFF, 32'h0,        1'b0}, // R10 dropped
    '{4'd10, 1'b0, 12'h030, 32'h0,        32'h0,        1'b0}, // R10
    '{4'd10, 1'b1, 12'h040, 32'h0,        32'h0,        1'b0}, // R10 unlock dropped
    '{4'd10, 1'b0, 12'h040, 32'h0,        32'h00000100, 1'b0}, // R10
    '{4'd10, 1'b1, 12'h010, 32'h30000000, 32'h0,        1'b0}, // R10 dec 0 free
    '{4'd10, 1'b0, 12'h010, 32'h0,        32'h30000000, 1'b0}, // R10
    '{4'd6,  1'b0, 12'h008, 32'h0,        32'h1,        1'b0}  // R6 status
  };

  logic               clk;
  logic               rst_n;
  logic               acc_rd;
  logic               acc_wr;
  logic [ADDR_W-1:0]  acc_addr;
  logic [3:0]         acc_be;
  logic [31:0]        acc_wdata;
  logic [31:0]        rsp_rdata;
  logic               rsp_err;
  logic               dec_global_en;
  logic [NUM_DEC-1:0] dec_committed;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  mdec_regfile #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_rd        (acc_rd),
    .acc_wr        (acc_wr),
    .acc_addr      (acc_addr),
    .acc_be        (acc_be),
    .acc_wdata     (acc_wdata),
    .rsp_rdata     (rsp_rdata),
    .rsp_err       (rsp_err),
    .dec_global_en (dec_global_en),
    .dec_committed (dec_committed)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one strobe for one cycle, sample the registered response
  task automatic access(input logic rd, input logic wr,
                        input logic [ADDR_W-1:0] addr, input logic [3:0] be,
                        input logic [31:0] wd,
                        output logic [31:0] rdata, output logic err);
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_addr = addr; acc_be = be; acc_wdata = wd;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0; acc_be = 4'h0; acc_wdata = '0;
    rdata = rsp_rdata;
    err   = rsp_err;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    rst_n = 1'b0; acc_rd = 1'b0; acc_wr = 1'b0;
    acc_addr = '0; acc_be = 4'h0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    access(1'b1, 1'b0, 12'h010, 4'hF, 32'h0, rd, er);
    check("R1", "base low after reset", rd, 32'h0);
    access(1'b1, 1'b0, 12'h020, 4'hF, 32'h0, rd, er);
    check("R1", "ctrl after reset", rd, 32'h0);
    check("R1", "committed port after reset", 32'(dec_committed), 32'h0);
    check("R1", "enable after reset", 32'(dec_global_en), 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      access(~VT[i].wr, VT[i].wr, VT[i].addr, 4'hF, VT[i].wdata, rd, er);
      n_checks++;
      if (rd !== VT[i].exp || er !== VT[i].err) begin
        n_fail++;
        $display("FAIL R%0d vector %0d actual=%h/%b expected=%h/%b",
                 VT[i].req, i, rd, er, VT[i].exp, VT[i].err);
      end
    end

    // R9 and R6: ports follow the registers
    check("R9", "committed port", 32'(dec_committed), 32'h1);
    check("R6", "global enable port", 32'(dec_global_en), 32'h1);

    // R2: misaligned and partial accesses
    access(1'b1, 1'b0, 12'h012, 4'hF, 32'h0, rd, er);
    check("R2", "misaligned read err", 32'(er), 32'h1);
    check("R2", "misaligned read data", rd, 32'h0);
    access(1'b0, 1'b1, 12'h010, 4'h3, 32'h0, rd, er);
    check("R2", "partial write err", 32'(er), 32'h1);
    access(1'b0, 1'b1, 12'h011, 4'hF, 32'h0, rd, er);
    check("R2", "misaligned write err", 32'(er), 32'h1);
    access(1'b0, 1'b1, 12'h022, 4'hF, 32'h0, rd, er);
    check("R2", "misaligned ctrl write err", 32'(er), 32'h1);
    access(1'b1, 1'b0, 12'h010, 4'hF, 32'h0, rd, er);
    check("R2", "base low kept", rd, 32'h30000000);
    check("R2", "committed kept", 32'(dec_committed), 32'h1);

    // R3: double strobe
    access(1'b1, 1'b1, 12'h004, 4'hF, 32'h0, rd, er);
    check("R3", "double strobe err", 32'(er), 32'h1);
    access(1'b1, 1'b0, 12'h004, 4'hF, 32'h0, rd, er);
    check("R3", "gctrl kept", rd, 32'h3);

    // R4: idle cycle after an access
    @(negedge clk);
    check("R4", "idle err", 32'(rsp_err), 32'h0);
    check("R4", "idle data", rsp_rdata, 32'h0);

    // R1: mid-run reset clears lock, commit and control
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "committed after reset", 32'(dec_committed), 32'h0);
    access(1'b1, 1'b0, 12'h040, 4'hF, 32'h0, rd, er);
    check("R1", "lock cleared", rd, 32'h0);
    access(1'b1, 1'b0, 12'h004, 4'hF, 32'h0, rd, er);
    check("R1", "gctrl cleared", rd, 32'h0);
    access(1'b1, 1'b0, 12'h000, 4'hF, 32'h0, rd, er);
    check("R1", "capability", rd, 32'h2);
    access(1'b0, 1'b1, 12'h030, 4'hF, 32'h50000000, rd, er);
    access(1'b1, 1'b0, 12'h030, 4'hF, 32'h0, rd, er);
    check("R10", "writable after reset unlock", rd, 32'h50000000);

    done = 1'b1;
    finish_run();
  end

endmodule